// File: doc/BRIEF.md
# Three-Wire to Two-Wire Bus Arbitration Bridge

This block joins a bus controller that arbitrates with three wires (request, grant, grant-acknowledge) to a fast CPU that arbitrates with only two (request and grant). The controller follows a fixed handshake. It waits for grant. One clock later it asserts acknowledge. About one and a half clocks after that it drops its request. A CPU with no acknowledge input would read that dropped request as the end of the external tenure and take the bus back. The bridge therefore gives the CPU a single merged request. That request stays asserted while either the controller request or the acknowledge is asserted. It is also held across a short window in which the request has already dropped but the acknowledge has not yet been seen.

In the other direction, the CPU grant is passed to the controller only once the CPU has finished its current bus cycle, which is when its address strobe is inactive. It is also passed only while a controller request is active. This keeps the controller from starting a DMA cycle while the CPU still drives the bus. Every input is asynchronous and passes through a synchronizer chain. Both outputs are registered. All external signals are active low, and the reset is synchronous and active high.

Top module: `arb_bridge`

## Requirements
- R1: After reset, `cpu_req_n` and `ctl_grant_n` are both high. A low `cpu_grant_n` with `cpu_as_n` high does not drive `ctl_grant_n` low while no controller request or acknowledge is active.
- R2: Each input passes through SYNC_STAGES flip-flops (default 2), and each output is registered. A change on an input reaches the outputs exactly SYNC_STAGES+1 clocks later (3 by default), and not earlier.
- R3: `cpu_req_n` is driven low whenever `ctl_req_n` or `ctl_ack_n` is low, after the R2 latency.
- R4: When `ctl_req_n` rises while `ctl_ack_n` is low, `cpu_req_n` stays low with no high cycle.
- R5: If the grant has already been passed to the controller and `ctl_req_n` rises before `ctl_ack_n` falls, `cpu_req_n` stays low for up to GAP_HOLD clocks (default 4). An acknowledge that arrives inside that window continues the tenure, and `cpu_req_n` has no high cycle.
- R6: If no acknowledge arrives within the R5 window, `cpu_req_n` goes high exactly GAP_HOLD clocks after the request release becomes visible (SYNC_STAGES+1+GAP_HOLD clocks after the input edge).
- R7: A request withdrawn before any grant was passed to the controller releases `cpu_req_n` with the plain R2 latency and no hold.
- R8: Once `ctl_ack_n` and `ctl_req_n` are both high after a tenure, `cpu_req_n` goes high after the R2 latency, and `ctl_grant_n` goes high in the same clock.
- R9: `ctl_grant_n` is low only while `cpu_grant_n` is low, `cpu_as_n` is high and a request is active (R3 to R5). While `cpu_as_n` is low the grant is withheld. The grant goes low at the R2 latency after `cpu_as_n` rises.
- R10: `ctl_grant_n` returns high at the R2 latency after either `cpu_grant_n` rises or `cpu_as_n` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ctl_req_n | input | 1 | Bus request from the three-wire controller, active low |
| ctl_ack_n | input | 1 | Grant-acknowledge from the controller, active low |
| cpu_grant_n | input | 1 | Bus grant from the two-wire CPU, active low |
| cpu_as_n | input | 1 | CPU address strobe, active low |
| cpu_req_n | output | 1 | Merged bus request to the CPU, active low |
| ctl_grant_n | output | 1 | Gated bus grant to the controller, active low |

## Verification
Every result is due a fixed number of clocks after the input edge that causes it. A plain request, release or grant change is due SYNC_STAGES+1 clocks later. Expiry of the gap hold is due SYNC_STAGES+1+GAP_HOLD clocks later. The driver changes inputs on a falling edge and queues each expected output pair with the exact cycle it is due. It often queues a second item one cycle earlier that still expects the old value, which catches a result that arrives too soon. The monitor samples at the falling edge of the due cycle, away from the register updates.

// File: rtl/arb_pkg.sv
package arb_pkg;

  // positions inside the synchronized input vector
  localparam int IN_REQ = 0;
  localparam int IN_ACK = 1;
  localparam int IN_GNT = 2;
  localparam int IN_AS  = 3;
  localparam int IN_NUM = 4;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,  // no external master interest
    ST_PEND   = 2'd1,  // request seen, tenure not yet acknowledged
    ST_GAP    = 2'd2,  // request dropped after grant, waiting for acknowledge
    ST_TENURE = 2'd3   // acknowledge held by the controller
  } arb_state_e;

endpackage

// File: rtl/arb_sync.sv
module arb_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/arb_req_merge.sv
module arb_req_merge
  import arb_pkg::*;
#(
  parameter int GAP_HOLD = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic req_act,      // synchronized controller request, active high
  input  logic ack_act,      // synchronized controller acknowledge, active high
  input  logic grant_given,  // grant currently passed to the controller
  output logic req_next,     // request state for the coming cycle
  output logic req_q         // registered CPU-side request, active high
);

  localparam int CNT_W = $clog2(GAP_HOLD + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(GAP_HOLD - 1);

  arb_state_e cur, nxt;
  logic [CNT_W-1:0] cnt, cnt_nxt;

  always_comb begin
    nxt     = cur;
    cnt_nxt = cnt;
    unique case (cur)
      ST_IDLE: begin
        if (ack_act)      nxt = ST_TENURE;
        else if (req_act) nxt = ST_PEND;
      end
      ST_PEND: begin
        if (ack_act) begin
          nxt = ST_TENURE;
        end else if (!req_act) begin
          if (grant_given) begin
            nxt     = ST_GAP;
            cnt_nxt = '0;
          end else begin
            nxt = ST_IDLE;
          end
        end
      end
      ST_GAP: begin
        if (ack_act)              nxt = ST_TENURE;
        else if (req_act)         nxt = ST_PEND;
        else if (cnt == CNT_LAST) nxt = ST_IDLE;
        else                      cnt_nxt = cnt + CNT_W'(1);
      end
      ST_TENURE: begin
        if (!ack_act) nxt = req_act ? ST_PEND : ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  assign req_next = (nxt != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur   <= ST_IDLE;
      cnt   <= '0;
      req_q <= 1'b0;
    end else begin
      cur   <= nxt;
      cnt   <= cnt_nxt;
      req_q <= req_next;
    end
  end

  AST_ACK_KEEPS_REQ: assert property (@(posedge clk) disable iff (rst)
    ack_act |=> req_q);  // R4

  AST_GAP_HELD: assert property (@(posedge clk) disable iff (rst)
    (cur == ST_GAP && cnt != CNT_LAST) |=> req_q);  // R5

  AST_GAP_EXPIRES: assert property (@(posedge clk) disable iff (rst)
    (cur == ST_GAP && cnt == CNT_LAST && !req_act && !ack_act) |=> !req_q);  // R6

  AST_WITHDRAW_FAST: assert property (@(posedge clk) disable iff (rst)
    (cur == ST_PEND && !req_act && !ack_act && !grant_given) |=> !req_q);  // R7

  AST_TENURE_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (cur == ST_TENURE && !req_act && !ack_act) |=> !req_q);  // R8

endmodule

// File: rtl/arb_grant_gate.sv
module arb_grant_gate (
  input  logic clk,
  input  logic rst,
  input  logic gnt_act,   // synchronized CPU grant, active high
  input  logic as_act,    // synchronized CPU address strobe, active high
  input  logic req_next,  // request state for the coming cycle
  output logic grant_q    // registered controller grant, active high
);

  always_ff @(posedge clk) begin
    if (rst) grant_q <= 1'b0;
    else     grant_q <= gnt_act && !as_act && req_next;
  end

  AST_AS_BLOCKS_GRANT: assert property (@(posedge clk) disable iff (rst)
    as_act |=> !grant_q);  // R9

  AST_GRANT_FOLLOWS_CPU: assert property (@(posedge clk) disable iff (rst)
    !gnt_act |=> !grant_q);  // R10

endmodule

// File: rtl/arb_bridge.sv
module arb_bridge
  import arb_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int GAP_HOLD    = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic ctl_req_n,
  input  logic ctl_ack_n,
  input  logic cpu_grant_n,
  input  logic cpu_as_n,
  output logic cpu_req_n,
  output logic ctl_grant_n
);

  logic [IN_NUM-1:0] raw_act, s_act;
  logic req_next, req_q, grant_q;

  // convert to active-high before synchronizing so reset means "deasserted"
  always_comb begin
    raw_act          = '0;
    raw_act[IN_REQ]  = ~ctl_req_n;
    raw_act[IN_ACK]  = ~ctl_ack_n;
    raw_act[IN_GNT]  = ~cpu_grant_n;
    raw_act[IN_AS]   = ~cpu_as_n;
  end

  arb_sync #(
    .WIDTH  (IN_NUM),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_act),
    .q   (s_act)
  );

  arb_req_merge #(
    .GAP_HOLD (GAP_HOLD)
  ) u_merge (
    .clk         (clk),
    .rst         (rst),
    .req_act     (s_act[IN_REQ]),
    .ack_act     (s_act[IN_ACK]),
    .grant_given (grant_q),
    .req_next    (req_next),
    .req_q       (req_q)
  );

  arb_grant_gate u_gate (
    .clk      (clk),
    .rst      (rst),
    .gnt_act  (s_act[IN_GNT]),
    .as_act   (s_act[IN_AS]),
    .req_next (req_next),
    .grant_q  (grant_q)
  );

  assign cpu_req_n   = ~req_q;
  assign ctl_grant_n = ~grant_q;

  AST_REQ_MERGED: assert property (@(posedge clk) disable iff (rst)
    (s_act[IN_REQ] || s_act[IN_ACK]) |=> !cpu_req_n);  // R3

  AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    $fell(ctl_grant_n) |-> !cpu_req_n);  // R9

endmodule

// File: tb/arb_bridge_bench.sv
module arb_bridge_bench;

  localparam int SYNC_STAGES = 2;
  localparam int GAP_HOLD    = 4;
  localparam int LAT         = SYNC_STAGES + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctl_req_n = 1'b1, ctl_ack_n = 1'b1, cpu_grant_n = 1'b1, cpu_as_n = 1'b1;
  logic cpu_req_n, ctl_grant_n;

  int cyc = 0;
  int n_checks = 0;
  int n_fail = 0;

  typedef struct {
    int    due;
    logic  exp_req_n;
    logic  exp_gnt_n;
    string tag;
  } item_t;

  item_t sb[$];

  always #10 clk = ~clk;  // 50 MHz

  always @(posedge clk) cyc <= cyc + 1;

  arb_bridge #(
    .SYNC_STAGES (SYNC_STAGES),
    .GAP_HOLD    (GAP_HOLD)
  ) u_arb_bridge (
    .clk         (clk),
    .rst         (rst),
    .ctl_req_n   (ctl_req_n),
    .ctl_ack_n   (ctl_ack_n),
    .cpu_grant_n (cpu_grant_n),
    .cpu_as_n    (cpu_as_n),
    .cpu_req_n   (cpu_req_n),
    .ctl_grant_n (ctl_grant_n)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(input logic r, input logic a, input logic g, input logic s);
    ctl_req_n   = r;
    ctl_ack_n   = a;
    cpu_grant_n = g;
    cpu_as_n    = s;
  endtask

  task automatic expect_at(input int dly, input logic r, input logic g, input string tag);
    item_t it;
    it.due       = cyc + dly;
    it.exp_req_n = r;
    it.exp_gnt_n = g;
    it.tag       = tag;
    sb.push_back(it);
  endtask

  // monitor: compares each queued item on its due cycle
  always @(negedge clk) begin : monitor
    item_t it;
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      it = sb.pop_front();
      n_checks++;
      if (it.due != cyc) begin
        n_fail++;
        $display("FAIL %s: missed due cycle, actual cycle %0d expected %0d", it.tag, cyc, it.due);
      end else if (cpu_req_n !== it.exp_req_n || ctl_grant_n !== it.exp_gnt_n) begin
        n_fail++;
        $display("FAIL %s: actual req_n=%b grant_n=%b expected req_n=%b grant_n=%b (cycle %0d)",
                 it.tag, cpu_req_n, ctl_grant_n, it.exp_req_n, it.exp_gnt_n, cyc);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual run still active, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : driver
    tick(4);
    rst = 1'b0;
    expect_at(1, 1'b1, 1'b1, "R1 reset state");
    tick(2);

    // R1: CPU grant without any controller request is not passed
    drive(1, 1, 0, 1);
    expect_at(LAT, 1'b1, 1'b1, "R1 no request no grant");
    expect_at(LAT + 2, 1'b1, 1'b1, "R1 no request no grant later");
    tick(LAT + 3);
    drive(1, 1, 1, 1);
    tick(4);

    // R2/R3: request merged with exact latency
    drive(0, 1, 1, 1);
    expect_at(LAT - 1, 1'b1, 1'b1, "R2 not before latency");
    expect_at(LAT, 1'b0, 1'b1, "R3 request reaches CPU");
    tick(LAT + 1);

    // R9: CPU grants while still in a bus cycle
    drive(0, 1, 0, 0);
    expect_at(LAT, 1'b0, 1'b1, "R9 grant withheld during strobe");
    tick(LAT + 1);
    drive(0, 1, 0, 1);
    expect_at(LAT - 1, 1'b0, 1'b1, "R2 grant not early");
    expect_at(LAT, 1'b0, 1'b0, "R9 grant after strobe ends");
    tick(2);

    // R4: acknowledge then request release, no gap
    drive(0, 0, 0, 1);
    expect_at(1, 1'b0, 1'b0, "R4 overlap start");
    tick(2);
    drive(1, 0, 0, 1);
    expect_at(1, 1'b0, 1'b0, "R4 overlap");
    expect_at(LAT, 1'b0, 1'b0, "R4 release seen");
    expect_at(LAT + 2, 1'b0, 1'b0, "R4 tenure held");
    tick(LAT + 4);

    // R8: tenure ends
    drive(1, 1, 0, 1);
    expect_at(LAT - 1, 1'b0, 1'b0, "R8 not before latency");
    expect_at(LAT, 1'b1, 1'b1, "R8 request and grant released");
    tick(LAT + 1);
    drive(1, 1, 1, 1);
    tick(4);

    // R5: request drops before acknowledge, hold bridges the gap
    drive(0, 1, 0, 1);
    expect_at(LAT, 1'b0, 1'b0, "R5 setup grant passed");
    tick(LAT + 1);
    drive(1, 1, 0, 1);
    expect_at(LAT, 1'b0, 1'b0, "R5 gap entered");
    expect_at(LAT + 1, 1'b0, 1'b0, "R5 gap held");
    tick(2);
    drive(1, 0, 0, 1);
    expect_at(LAT, 1'b0, 1'b0, "R5 acknowledge joins");
    expect_at(LAT + 2, 1'b0, 1'b0, "R5 tenure continues");
    tick(LAT + 4);
    drive(1, 1, 0, 1);
    expect_at(LAT, 1'b1, 1'b1, "R8 release after bridged tenure");
    tick(LAT + 1);

    // R6: hold expires when no acknowledge comes
    drive(0, 1, 0, 1);
    expect_at(LAT, 1'b0, 1'b0, "R3 request with grant");
    tick(LAT + 1);
    drive(1, 1, 0, 1);
    expect_at(LAT + GAP_HOLD - 1, 1'b0, 1'b0, "R5 held until window end");
    expect_at(LAT + GAP_HOLD, 1'b1, 1'b1, "R6 hold expired");
    tick(LAT + GAP_HOLD + 2);
    drive(1, 1, 1, 1);
    tick(4);

    // R7: request withdrawn before grant
    drive(0, 1, 1, 1);
    tick(LAT + 1);
    drive(1, 1, 1, 1);
    expect_at(LAT - 1, 1'b0, 1'b1, "R7 still requesting");
    expect_at(LAT, 1'b1, 1'b1, "R7 released with no hold");
    tick(LAT + 2);

    // R10: grant removed by strobe then by CPU grant release
    drive(0, 1, 0, 1);
    expect_at(LAT, 1'b0, 1'b0, "R9 grant passed");
    tick(LAT + 1);
    drive(0, 1, 0, 0);
    expect_at(LAT - 1, 1'b0, 1'b0, "R10 not before latency");
    expect_at(LAT, 1'b0, 1'b1, "R10 strobe removes grant");
    tick(LAT + 1);
    drive(0, 1, 0, 1);
    expect_at(LAT, 1'b0, 1'b0, "R9 grant returns");
    tick(LAT + 1);
    drive(0, 1, 1, 1);
    expect_at(LAT, 1'b0, 1'b1, "R10 CPU grant release");
    tick(LAT + 1);
    drive(1, 1, 1, 1);
    expect_at(LAT, 1'b1, 1'b1, "R7 final release");
    tick(LAT + 1);

    wait (sb.size() == 0);
    tick(2);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule